// File: doc/BRIEF.md
# Prefix-Escape Byte Instruction Decoder

This block turns a stream of one-byte instruction codes for an eight-register machine into resolved micro-operations. A plain byte is a two-register move. Escape bytes placed in front of that move change it: one kind selects an ALU function from a common or a rare group of eight, and another kind supplies a third register so the operation becomes three-address. The escape bytes leave no visible result of their own. They are kept as hidden state until the terminating move byte arrives. The decoder then emits one micro-op and clears that state.

Bytes enter through a valid/ready pair. Each micro-op leaves as a one-cycle valid pulse carrying its kind, function, destination and two source registers. While an escape is pending, an interrupt-hold output tells the surrounding core not to break the sequence. Reserved byte codes produce a one-cycle illegal pulse and discard any pending escape.

Top module: `pfxdec_top`

## Requirements
- R1: While reset is asserted, uop_valid, illegal and int_hold are 0 and in_ready is 0. From the first clock edge after reset is released, in_ready is 1.
- R2: A byte 00-sss-ddd with no pending ALU escape produces, in the cycle after it is accepted, uop_valid=1 with kind MOVE (code 0), func 0, dst=ddd, src_a=sss and src_b=0.
- R3: A common escape 01-000-aaa followed by a move 00-sss-ddd produces kind ALU2 (code 1), func {0,aaa}, dst=ddd, src_a=ddd and src_b=sss.
- R4: A rare escape 01-001-bbb followed by a move produces func {1,bbb}. The register fields are the same as in R3.
- R5: A register escape 10-ppp-rrr together with an ALU escape, followed by move 00-sss-ddd, produces kind ALU3 (code 2), dst=ddd, src_a=sss and src_b=rrr. The ppp field has no effect.
- R6: When several escapes of the same kind come before one move, the last one wins.
- R7: int_hold is 1 from the cycle after an escape byte is accepted until the cycle in which the resulting uop_valid (or illegal) appears. In that cycle it is 0. Idle cycles do not clear it.
- R8: A byte with top bits 11, or with top bits 01 and a middle field other than 000 or 001, raises illegal for one cycle in the cycle after acceptance. It emits no micro-op and discards all pending escapes.
- R9: A register escape with no ALU escape before the move yields a plain MOVE, as in R2.
- R10: A byte offered with in_valid=0 is ignored: no uop_valid, no illegal and no change to pending state.
- R11: An escape byte by itself never raises uop_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction byte present |
| in_ready | output | 1 | Decoder accepts a byte |
| in_byte | input | 8 | Instruction byte |
| uop_valid | output | 1 | One-cycle micro-op pulse |
| uop_kind | output | 2 | 0 move, 1 two-address ALU, 2 three-address ALU |
| uop_func | output | 4 | {rare, function} |
| uop_dst | output | 3 | Destination register |
| uop_src_a | output | 3 | First source register |
| uop_src_b | output | 3 | Second source register |
| illegal | output | 1 | Reserved byte pulse |
| int_hold | output | 1 | Escape pending, hold interrupts |

## Verification
The pending escape state is hidden, so a fault in it shows up at the ports only later. int_hold shows it one cycle after the escape byte. The micro-op fields show it one cycle after the next move. The bench compares int_hold on every cycle, so a wrong set or clear is caught at once. It also runs escape sequences separated by idle cycles, repeated escapes and interrupting reserved bytes, so that stale or lost prefix state appears in the very next micro-op.

// File: rtl/pfxdec_pkg.sv
package pfxdec_pkg;
  typedef enum logic [1:0] {
    K_MOVE = 2'd0,
    K_ALU2 = 2'd1,
    K_ALU3 = 2'd2,
    K_RSVD = 2'd3
  } uop_kind_t;

  typedef enum logic [1:0] {
    C_MOVE   = 2'd0,
    C_ALUPFX = 2'd1,
    C_REGPFX = 2'd2,
    C_BAD    = 2'd3
  } byte_cls_t;
endpackage

// File: rtl/pfxdec_classify.sv
module pfxdec_classify #(
  parameter int REG_W = 3
) (
  input  logic [2*REG_W+1:0]     byte_i,
  output pfxdec_pkg::byte_cls_t  cls_o,
  output logic                   rare_o,
  output logic [REG_W-1:0]       mid_o,
  output logic [REG_W-1:0]       lo_o
);
  import pfxdec_pkg::*;
  localparam int BYTE_W = 2*REG_W + 2;

  logic [1:0] top;
  assign top   = byte_i[BYTE_W-1 -: 2];
  assign mid_o = byte_i[2*REG_W-1:REG_W];
  assign lo_o  = byte_i[REG_W-1:0];

  always_comb begin
    rare_o = 1'b0;
    unique case (top)
      2'b00: cls_o = C_MOVE;
      2'b01: begin
        if (mid_o == REG_W'(0))      cls_o = C_ALUPFX;
        else if (mid_o == REG_W'(1)) begin
          cls_o  = C_ALUPFX;
          rare_o = 1'b1;
        end else                     cls_o = C_BAD;
      end
      2'b10: cls_o = C_REGPFX;
      default: cls_o = C_BAD;
    endcase
  end
endmodule

// File: rtl/pfxdec_prefix.sv
module pfxdec_prefix #(
  parameter int REG_W = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  take_i,
  input  pfxdec_pkg::byte_cls_t cls_i,
  input  logic                  rare_i,
  input  logic [REG_W-1:0]      lo_i,
  output logic                  alu_set_o,
  output logic [REG_W:0]        alu_func_o,
  output logic                  r3_set_o,
  output logic [REG_W-1:0]      r3_o
);
  import pfxdec_pkg::*;

  logic             alu_set_d, r3_set_d;
  logic [REG_W:0]   alu_func_d;
  logic [REG_W-1:0] r3_d;

  always_comb begin
    alu_set_d  = alu_set_o;
    alu_func_d = alu_func_o;
    r3_set_d   = r3_set_o;
    r3_d       = r3_o;
    if (take_i) begin
      unique case (cls_i)
        C_ALUPFX: begin
          alu_set_d  = 1'b1;
          alu_func_d = {rare_i, lo_i};
        end
        C_REGPFX: begin
          r3_set_d = 1'b1;
          r3_d     = lo_i;
        end
        default: begin
          alu_set_d = 1'b0;
          r3_set_d  = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alu_set_o  <= 1'b0;
      alu_func_o <= '0;
      r3_set_o   <= 1'b0;
      r3_o       <= '0;
    end else if (take_i) begin
      alu_set_o  <= alu_set_d;
      alu_func_o <= alu_func_d;
      r3_set_o   <= r3_set_d;
      r3_o       <= r3_d;
    end
  end

  // R7: an accepted escape leaves something pending on the next cycle
  p_escape_pends_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && (cls_i == C_ALUPFX || cls_i == C_REGPFX)) |=> (alu_set_o || r3_set_o));

  // R8: a reserved byte discards every pending escape
  p_bad_discards_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && cls_i == C_BAD) |=> (!alu_set_o && !r3_set_o));
endmodule

// File: rtl/pfxdec_resolve.sv
module pfxdec_resolve #(
  parameter int REG_W = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  take_i,
  input  pfxdec_pkg::byte_cls_t cls_i,
  input  logic [REG_W-1:0]      sss_i,
  input  logic [REG_W-1:0]      ddd_i,
  input  logic                  alu_set_i,
  input  logic [REG_W:0]        alu_func_i,
  input  logic                  r3_set_i,
  input  logic [REG_W-1:0]      r3_i,
  output logic                  valid_o,
  output logic [1:0]            kind_o,
  output logic [REG_W:0]        func_o,
  output logic [REG_W-1:0]      dst_o,
  output logic [REG_W-1:0]      src_a_o,
  output logic [REG_W-1:0]      src_b_o,
  output logic                  illegal_o
);
  import pfxdec_pkg::*;

  logic             emit, bad;
  uop_kind_t        kind_d;
  logic [REG_W:0]   func_d;
  logic [REG_W-1:0] src_a_d, src_b_d;

  assign emit = take_i && (cls_i == C_MOVE);
  assign bad  = take_i && (cls_i == C_BAD);

  always_comb begin
    if (!alu_set_i) begin
      kind_d  = K_MOVE;
      func_d  = '0;
      src_a_d = sss_i;
      src_b_d = '0;
    end else if (!r3_set_i) begin
      kind_d  = K_ALU2;
      func_d  = alu_func_i;
      src_a_d = ddd_i;
      src_b_d = sss_i;
    end else begin
      kind_d  = K_ALU3;
      func_d  = alu_func_i;
      src_a_d = sss_i;
      src_b_d = r3_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o   <= 1'b0;
      illegal_o <= 1'b0;
    end else begin
      valid_o   <= emit;
      illegal_o <= bad;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_o  <= '0;
      func_o  <= '0;
      dst_o   <= '0;
      src_a_o <= '0;
      src_b_o <= '0;
    end else if (emit) begin
      kind_o  <= kind_d;
      func_o  <= func_d;
      dst_o   <= ddd_i;
      src_a_o <= src_a_d;
      src_b_o <= src_b_d;
    end
  end

  // R2: the reserved kind code never leaves the decoder
  p_kind_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (kind_o != 2'd3));

  // R8: a micro-op and an illegal pulse never coincide
  p_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(valid_o && illegal_o));
endmodule

// File: rtl/pfxdec_top.sv
module pfxdec_top #(
  parameter int REG_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [2*REG_W+1:0] in_byte,
  output logic               uop_valid,
  output logic [1:0]         uop_kind,
  output logic [REG_W:0]     uop_func,
  output logic [REG_W-1:0]   uop_dst,
  output logic [REG_W-1:0]   uop_src_a,
  output logic [REG_W-1:0]   uop_src_b,
  output logic               illegal,
  output logic               int_hold
);
  import pfxdec_pkg::*;

  byte_cls_t        cls;
  logic             rare, take, alu_set, r3_set;
  logic [REG_W-1:0] mid, lo, r3;
  logic [REG_W:0]   alu_func;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) in_ready <= 1'b0;
    else        in_ready <= 1'b1;
  end

  assign take     = in_valid && in_ready;
  assign int_hold = alu_set || r3_set;

  pfxdec_classify #(.REG_W(REG_W)) u_cls (
    .byte_i(in_byte), .cls_o(cls), .rare_o(rare), .mid_o(mid), .lo_o(lo)
  );

  pfxdec_prefix #(.REG_W(REG_W)) u_pfx (
    .clk(clk), .rst_n(rst_n), .take_i(take), .cls_i(cls), .rare_i(rare),
    .lo_i(lo), .alu_set_o(alu_set), .alu_func_o(alu_func),
    .r3_set_o(r3_set), .r3_o(r3)
  );

  pfxdec_resolve #(.REG_W(REG_W)) u_res (
    .clk(clk), .rst_n(rst_n), .take_i(take), .cls_i(cls),
    .sss_i(mid), .ddd_i(lo), .alu_set_i(alu_set), .alu_func_i(alu_func),
    .r3_set_i(r3_set), .r3_i(r3),
    .valid_o(uop_valid), .kind_o(uop_kind), .func_o(uop_func),
    .dst_o(uop_dst), .src_a_o(uop_src_a), .src_b_o(uop_src_b),
    .illegal_o(illegal)
  );

  // R10: an idle input cycle yields neither output pulse
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!uop_valid && !illegal));

  // R7: hold is released by the time the micro-op or illegal pulse appears
  p_hold_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (uop_valid || illegal) |-> !int_hold);

  // R10: idle cycles leave the hold state unchanged
  p_idle_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && in_ready) |=> $stable(int_hold));
endmodule

// File: tb/tb_pfxdec_top.sv
module tb_pfxdec_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic       clk = 1'b0;
  logic       rst_n, in_valid, in_ready, uop_valid, illegal, int_hold;
  logic [7:0] in_byte;
  logic [1:0] uop_kind;
  logic [3:0] uop_func;
  logic [2:0] uop_dst, uop_src_a, uop_src_b;

  int checks = 0, failures = 0;
  bit done = 0;

  // reference model state
  bit m_alu = 0, m_r3 = 0;
  int m_func = 0, m_r3v = 0;
  bit e_valid = 0, e_ill = 0;
  int e_kind = 0, e_func = 0, e_dst = 0, e_a = 0, e_b = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pfxdec_top dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_byte(in_byte), .uop_valid(uop_valid), .uop_kind(uop_kind),
    .uop_func(uop_func), .uop_dst(uop_dst), .uop_src_a(uop_src_a),
    .uop_src_b(uop_src_b), .illegal(illegal), .int_hold(int_hold)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] mv(input int s, input int d);
    return {2'b00, 3'(s), 3'(d)};
  endfunction
  function automatic logic [7:0] com(input int f); return {5'b01000, 3'(f)}; endfunction
  function automatic logic [7:0] rar(input int f); return {5'b01001, 3'(f)}; endfunction
  function automatic logic [7:0] rp(input int p, input int r);
    return {2'b10, 3'(p), 3'(r)};
  endfunction

  task automatic model(input logic v, input logic [7:0] b);
    int top, mid, lo;
    e_valid = 0; e_ill = 0;
    if (!v) return;
    top = b / 64; mid = (b / 8) % 8; lo = b % 8;
    if (top == 0) begin
      e_valid = 1; e_dst = lo;
      if (!m_alu) begin e_kind = 0; e_func = 0; e_a = mid; e_b = 0; end
      else if (!m_r3) begin e_kind = 1; e_func = m_func; e_a = lo; e_b = mid; end
      else begin e_kind = 2; e_func = m_func; e_a = mid; e_b = m_r3v; end
      m_alu = 0; m_r3 = 0;
    end else if (top == 1 && mid < 2) begin
      m_alu = 1; m_func = mid * 8 + lo;
    end else if (top == 2) begin
      m_r3 = 1; m_r3v = lo;
    end else begin
      e_ill = 1; m_alu = 0; m_r3 = 0;
    end
  endtask

  task automatic step(input string req, input logic v, input logic [7:0] b);
    in_valid = v; in_byte = b;
    @(posedge clk); #1;
    model(v, b);
    @(negedge clk);
    chk(req, "uop_valid", int'(uop_valid), int'(e_valid));
    chk(req, "illegal", int'(illegal), int'(e_ill));
    chk("R7", "int_hold", int'(int_hold), int'(m_alu || m_r3));
    chk("R1", "in_ready", int'(in_ready), 1);
    if (e_valid && uop_valid) begin
      chk(req, "kind", int'(uop_kind), e_kind);
      chk(req, "func", int'(uop_func), e_func);
      chk(req, "dst", int'(uop_dst), e_dst);
      chk(req, "src_a", int'(uop_src_a), e_a);
      chk(req, "src_b", int'(uop_src_b), e_b);
    end
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_byte = 8'h00;
    repeat (3) @(negedge clk);
    chk("R1", "reset uop_valid", int'(uop_valid), 0);
    chk("R1", "reset illegal", int'(illegal), 0);
    chk("R1", "reset int_hold", int'(int_hold), 0);
    chk("R1", "reset in_ready", int'(in_ready), 0);
    rst_n = 1'b1;
    @(negedge clk);

    step("R2", 1, mv(3, 5));
    step("R2", 1, mv(7, 0));
    step("R10", 0, mv(1, 1));
    step("R10", 0, com(2));
    step("R3", 1, com(6));
    step("R3", 1, mv(2, 4));
    step("R4", 1, rar(5));
    step("R4", 1, mv(6, 1));
    step("R5", 1, rp(7, 6));
    step("R5", 1, com(2));
    step("R5", 1, mv(1, 3));
    step("R6", 1, com(1));
    step("R6", 1, rar(7));
    step("R6", 1, rp(0, 2));
    step("R6", 1, rp(3, 5));
    step("R6", 1, mv(4, 4));
    step("R7", 1, com(3));
    step("R7", 0, 8'h00);
    step("R7", 0, 8'h00);
    step("R7", 1, mv(0, 7));
    step("R9", 1, rp(1, 4));
    step("R9", 1, mv(5, 2));
    step("R8", 1, com(4));
    step("R8", 1, 8'hC5);
    step("R8", 1, mv(2, 2));
    step("R8", 1, rp(0, 3));
    step("R8", 1, 8'b01010011);
    step("R8", 1, mv(3, 6));
    step("R11", 1, com(0));
    step("R11", 1, rar(0));
    step("R11", 1, mv(1, 0));

    for (int i = 0; i < 400; i++) begin
      logic [7:0] b;
      b = 8'($urandom);
      if (($urandom % 3) != 0) b[7] = 1'b0;
      step("R6", (($urandom % 4) != 0), b);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule